// File: doc/BRIEF.md
# ADC Calibration Sequencer

This block runs the calibration sequences of a delta-sigma converter. A host writes a 3-bit operating-mode field. A calibration code starts a sequence, and the sequencer raises a ready flag. It drives that flag on a pin and also as a status bit that the host may poll at any time. The sequencer then counts filter output periods, which arrive as one-cycle conversion-valid strobes. The number of periods depends on the calibration type and on the chop setting.

On the final period, the sequencer captures the 24-bit conversion result. Zero-scale modes store it in the offset coefficient of the channel that was selected at the start. Full-scale modes store it in that channel's gain coefficient. On the same edge the ready flag drops and the mode field returns to idle.

While a sequence runs, the sequencer forces two things on the filter and excitation paths. The fast-response and skip requests to the filter are held off. For the internal modes, the excitation is forced to dc. The modulator, the filter and the correction arithmetic are not part of this block.

Top module: `cal_seq_ctrl`

## Requirements
- R1: Writing a code with bit 2 set (4 = internal zero-scale, 5 = internal full-scale, 6 = system zero-scale, 7 = system full-scale) while idle loads it into the mode field and raises the ready flag on the next clock edge.
- R2: The status bit equals the ready pin in every cycle.
- R3: A sequence ends on strobe number N counted from its start. With chop set at the start, N is 22 for codes 4, 6 and 7 and 44 for code 5. With chop clear, N is 24 and 48. Chop and channel are sampled when the sequence starts.
- R4: On the final strobe, the result is written to the offset coefficient of the latched channel for codes 4 and 6, or to its gain coefficient for codes 5 and 7. No other coefficient changes.
- R5: On the edge that ends a sequence, the ready flag falls and the mode field becomes 000.
- R6: While the ready flag is high, the filter fast and skip outputs are 0. Otherwise they follow their request inputs.
- R7: The excitation output is 0 during codes 4 and 5. In every other cycle it follows the ac input.
- R8: Mode writes made while the ready flag is high leave the mode field, the length and the target unchanged.
- R9: A code with bit 2 clear is stored in the mode field. It does not raise the ready flag, and strobes then change no coefficient.
- R10: After reset the mode field is 000, ready is low, every offset coefficient reads 0x800000 and every gain coefficient reads 0x500000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode field write strobe |
| mode_wdata | input | 3 | Mode code to write |
| chan_sel | input | 1 | Channel to calibrate |
| chop_en | input | 1 | Chop setting |
| ac_bit | input | 1 | AC excitation request |
| fast_req | input | 1 | Filter fast-response request |
| skip_req | input | 1 | Filter skip request |
| conv_valid | input | 1 | One-cycle filter output strobe |
| conv_result | input | 24 | Filter output word |
| rd_chan | input | 1 | Channel whose coefficients are read |
| mode_q | output | 3 | Current mode field |
| rdy_pin | output | 1 | Ready flag, pin |
| rdy_status | output | 1 | Ready flag, status bit |
| filt_fast | output | 1 | Fast-response control to filter |
| filt_skip | output | 1 | Skip control to filter |
| exc_ac | output | 1 | AC excitation control |
| offset_rd | output | 24 | Offset coefficient of rd_chan |
| gain_rd | output | 24 | Gain coefficient of rd_chan |

## Verification
A period counter that is off by one moves the falling edge of ready by one strobe. The bench sees this on the strobe before or after the expected one. A wrong latched channel or target shows up when all four coefficients are read back after each sequence. A mode field that fails to lock, or fails to clear, is visible on mode_q one cycle after the write or after the final strobe.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    localparam int LEN_W = 7;
    localparam int DATA_W = 24;

    typedef enum logic [1:0] {
        CK_INT_ZS = 2'b00,
        CK_INT_FS = 2'b01,
        CK_SYS_ZS = 2'b10,
        CK_SYS_FS = 2'b11
    } cal_kind_e;

    typedef struct packed {
        logic             valid;
        cal_kind_e        kind;
        logic [LEN_W-1:0] len;
    } cal_plan_t;

    function automatic logic kind_is_gain(cal_kind_e k);
        return (k == CK_INT_FS) || (k == CK_SYS_FS);
    endfunction

    function automatic logic kind_is_internal(cal_kind_e k);
        return (k == CK_INT_ZS) || (k == CK_INT_FS);
    endfunction

endpackage

// File: rtl/cal_mode_decoder.sv
module cal_mode_decoder
    import cal_seq_pkg::*;
#(
    parameter int SHORT_CHOP   = 22,
    parameter int LONG_CHOP    = 44,
    parameter int SHORT_NOCHOP = 24,
    parameter int LONG_NOCHOP  = 48
) (
    input  logic [2:0] code,
    input  logic       chop,
    output cal_plan_t  plan
);
    always_comb begin
        plan.valid = code[2];
        plan.kind  = cal_kind_e'(code[1:0]);
        if (plan.kind == CK_INT_FS)
            plan.len = chop ? LEN_W'(LONG_CHOP) : LEN_W'(LONG_NOCHOP);
        else
            plan.len = chop ? LEN_W'(SHORT_CHOP) : LEN_W'(SHORT_NOCHOP);
    end
endmodule

// File: rtl/cal_period_counter.sv
module cal_period_counter
    import cal_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             strobe,
    input  logic [LEN_W-1:0] len,
    output logic             last
);
    logic [LEN_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (en && strobe)
            cnt <= cnt + LEN_W'(1);
    end

    assign last = en && strobe && (cnt == len - LEN_W'(1));
endmodule

// File: rtl/cal_coef_bank.sv
module cal_coef_bank
    import cal_seq_pkg::*;
#(
    parameter int                NCH      = 2,
    parameter logic [DATA_W-1:0] OFF_RST  = 24'h800000,
    parameter logic [DATA_W-1:0] GAIN_RST = 24'h500000,
    localparam int               CH_W     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_gain,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [DATA_W-1:0] off_out,
    output logic [DATA_W-1:0] gain_out
);
    logic [DATA_W-1:0] off_q  [NCH];
    logic [DATA_W-1:0] gain_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                off_q[g]  <= OFF_RST;
                gain_q[g] <= GAIN_RST;
            end else if (wr_en && wr_ch == CH_W'(g)) begin
                if (wr_gain) gain_q[g] <= wr_data;
                else         off_q[g]  <= wr_data;
            end
        end
    end

    assign off_out  = off_q[rd_ch];
    assign gain_out = gain_q[rd_ch];
endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
    import cal_seq_pkg::*;
#(
    parameter int NCH          = 2,
    parameter int SHORT_CHOP   = 22,
    parameter int LONG_CHOP    = 44,
    parameter int SHORT_NOCHOP = 24,
    parameter int LONG_NOCHOP  = 48,
    localparam int CH_W        = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [2:0]        mode_wdata,
    input  logic [CH_W-1:0]   chan_sel,
    input  logic              chop_en,
    input  logic              ac_bit,
    input  logic              fast_req,
    input  logic              skip_req,
    input  logic              conv_valid,
    input  logic [DATA_W-1:0] conv_result,
    input  logic [CH_W-1:0]   rd_chan,
    output logic [2:0]        mode_q,
    output logic              rdy_pin,
    output logic              rdy_status,
    output logic              filt_fast,
    output logic              filt_skip,
    output logic              exc_ac,
    output logic [DATA_W-1:0] offset_rd,
    output logic [DATA_W-1:0] gain_rd
);
    cal_plan_t       new_plan;
    cal_plan_t       plan_q;
    logic [CH_W-1:0] ch_q;
    logic            running;
    logic            start;
    logic            last;

    cal_mode_decoder #(
        .SHORT_CHOP  (SHORT_CHOP),
        .LONG_CHOP   (LONG_CHOP),
        .SHORT_NOCHOP(SHORT_NOCHOP),
        .LONG_NOCHOP (LONG_NOCHOP)
    ) u_dec (
        .code(mode_wdata),
        .chop(chop_en),
        .plan(new_plan)
    );

    assign start = !running && mode_wr && new_plan.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            mode_q  <= 3'b000;
            plan_q  <= '0;
            ch_q    <= '0;
        end else if (!running) begin
            if (mode_wr) mode_q <= mode_wdata;
            if (start) begin
                running <= 1'b1;
                plan_q  <= new_plan;
                ch_q    <= chan_sel;
            end
        end else if (last) begin
            running <= 1'b0;
            mode_q  <= 3'b000;
        end
    end

    cal_period_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (start),
        .en    (running),
        .strobe(conv_valid),
        .len   (plan_q.len),
        .last  (last)
    );

    cal_coef_bank #(.NCH(NCH)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (last),
        .wr_gain (kind_is_gain(plan_q.kind)),
        .wr_ch   (ch_q),
        .wr_data (conv_result),
        .rd_ch   (rd_chan),
        .off_out (offset_rd),
        .gain_out(gain_rd)
    );

    assign rdy_pin    = running;
    assign rdy_status = running;
    assign filt_fast  = fast_req && !running;
    assign filt_skip  = skip_req && !running;
    assign exc_ac     = ac_bit && !(running && kind_is_internal(plan_q.kind));
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       mode_wr,
    input logic [2:0] mode_wdata,
    input logic       conv_valid,
    input logic       ac_bit,
    input logic [2:0] mode_q,
    input logic       rdy_pin,
    input logic       rdy_status,
    input logic       filt_fast,
    input logic       filt_skip,
    input logic       exc_ac
);
    p_start_r1: assert property (@(posedge clk) disable iff (rst)
        (!rdy_pin && mode_wr && mode_wdata[2]) |=> (rdy_pin && mode_q == $past(mode_wdata)));

    p_status_r2: assert property (@(posedge clk) disable iff (rst)
        rdy_status == rdy_pin);

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy_pin) |-> (mode_q == 3'b000));

    p_filter_r6: assert property (@(posedge clk) disable iff (rst)
        rdy_pin |-> (!filt_fast && !filt_skip));

    p_dc_exc_r7: assert property (@(posedge clk) disable iff (rst)
        (rdy_pin && !mode_q[1]) |-> !exc_ac);

    p_sys_exc_r7: assert property (@(posedge clk) disable iff (rst)
        (rdy_pin && mode_q[1]) |-> (exc_ac == ac_bit));

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rdy_pin && !conv_valid) |=> (rdy_pin && $stable(mode_q)));

    p_no_start_r9: assert property (@(posedge clk) disable iff (rst)
        (!rdy_pin && mode_wr && !mode_wdata[2]) |=> !rdy_pin);
endmodule

bind cal_seq_ctrl cal_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_wr   (mode_wr),
    .mode_wdata(mode_wdata),
    .conv_valid(conv_valid),
    .ac_bit    (ac_bit),
    .mode_q    (mode_q),
    .rdy_pin   (rdy_pin),
    .rdy_status(rdy_status),
    .filt_fast (filt_fast),
    .filt_skip (filt_skip),
    .exc_ac    (exc_ac)
);

// File: tb/cal_seq_ctrl_tb_top.sv
module cal_seq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_wr = 1'b0;
    logic [2:0]  mode_wdata = 3'b000;
    logic        chan_sel = 1'b0;
    logic        chop_en = 1'b0;
    logic        ac_bit = 1'b0;
    logic        fast_req = 1'b1;
    logic        skip_req = 1'b1;
    logic        conv_valid = 1'b0;
    logic [23:0] conv_result = '0;
    logic        rd_chan = 1'b0;
    logic [2:0]  mode_q;
    logic        rdy_pin, rdy_status, filt_fast, filt_skip, exc_ac;
    logic [23:0] offset_rd, gain_rd;

    int n_vec = 0;
    int n_bad = 0;
    logic [23:0] m_off [2];
    logic [23:0] m_gain[2];

    always #10 clk = ~clk;

    cal_seq_ctrl dut_i (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .chan_sel(chan_sel), .chop_en(chop_en), .ac_bit(ac_bit),
        .fast_req(fast_req), .skip_req(skip_req), .conv_valid(conv_valid),
        .conv_result(conv_result), .rd_chan(rd_chan), .mode_q(mode_q),
        .rdy_pin(rdy_pin), .rdy_status(rdy_status), .filt_fast(filt_fast),
        .filt_skip(filt_skip), .exc_ac(exc_ac), .offset_rd(offset_rd),
        .gain_rd(gain_rd)
    );

    task automatic chk(input logic ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_coefs(input string tag);
        for (int c = 0; c < 2; c++) begin
            rd_chan = c[0];
            #1;
            chk(offset_rd == m_off[c], {tag, " offset"}, offset_rd, m_off[c]);
            chk(gain_rd == m_gain[c], {tag, " gain"}, gain_rd, m_gain[c]);
        end
    endtask

    task automatic strobe(input logic [23:0] v);
        conv_valid = 1'b1;
        conv_result = v;
        @(negedge clk);
        conv_valid = 1'b0;
        conv_result = '0;
    endtask

    task automatic run_one(input logic [2:0] code, input logic chop, input logic ch, input logic ac, input int idx);
        int len;
        logic is_cal;
        logic [23:0] val;
        is_cal = code[2];
        if (code == 3'b101) len = chop ? 44 : 48;
        else                len = chop ? 22 : 24;
        @(negedge clk);
        mode_wr = 1'b1; mode_wdata = code; chop_en = chop; chan_sel = ch; ac_bit = ac;
        @(negedge clk);
        mode_wr = 1'b0;
        chk(mode_q == code, "R1 mode load", {21'b0, mode_q}, {21'b0, code});
        chk(rdy_pin == is_cal, "R1 ready rise", {23'b0, rdy_pin}, {23'b0, is_cal});
        chk(rdy_status == rdy_pin, "R2 status", {23'b0, rdy_status}, {23'b0, rdy_pin});
        chan_sel = ~ch; chop_en = ~chop;
        if (is_cal) begin
            for (int k = 0; k < len; k++) begin
                val = 24'(idx * 24'h010307 + k * 24'h000111 + 24'h00A5A5);
                chk(!filt_fast && !filt_skip, "R6 filter forced", {22'b0, filt_fast, filt_skip}, 24'h0);
                chk(exc_ac == (ac && code[1]), "R7 excitation", {23'b0, exc_ac}, {23'b0, (ac && code[1])});
                if (k == 2) begin
                    mode_wr = 1'b1; mode_wdata = code ^ 3'b011;
                    @(negedge clk);
                    mode_wr = 1'b0;
                    chk(mode_q == code && rdy_pin, "R8 busy write ignored", {21'b0, mode_q}, {21'b0, code});
                end
                strobe(val);
                chk(rdy_pin == (k != len - 1), "R3 length", {23'b0, rdy_pin}, {23'b0, (k != len - 1)});
                chk(rdy_status == rdy_pin, "R2 status", {23'b0, rdy_status}, {23'b0, rdy_pin});
                if (k == len - 1) begin
                    chk(mode_q == 3'b000, "R5 mode clear", {21'b0, mode_q}, 24'h0);
                    if (code[0]) m_gain[ch] = val; else m_off[ch] = val;
                end
                @(negedge clk);
            end
            chk_coefs("R4 target");
            chk(filt_fast && filt_skip, "R6 filter follows", {22'b0, filt_fast, filt_skip}, 24'h3);
            chk(exc_ac == ac, "R7 idle excitation", {23'b0, exc_ac}, {23'b0, ac});
        end else begin
            for (int k = 0; k < 3; k++) begin
                strobe(24'hDEAD00 + 24'(k));
                chk(!rdy_pin && mode_q == code, "R9 no start", {21'b0, mode_q}, {21'b0, code});
            end
            chk_coefs("R9 coefs unchanged");
            mode_wr = 1'b1; mode_wdata = 3'b000;
            @(negedge clk);
            mode_wr = 1'b0;
        end
    endtask

    initial begin
        m_off[0] = 24'h800000; m_off[1] = 24'h800000;
        m_gain[0] = 24'h500000; m_gain[1] = 24'h500000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(mode_q == 3'b000, "R10 reset mode", {21'b0, mode_q}, 24'h0);
        chk(!rdy_pin && !rdy_status, "R10 reset ready", {22'b0, rdy_pin, rdy_status}, 24'h0);
        chk_coefs("R10 reset coefs");
        for (int c = 0; c < 8; c++)
            for (int p = 0; p < 2; p++)
                for (int h = 0; h < 2; h++)
                    for (int a = 0; a < 2; a++)
                        run_one(c[2:0], p[0], h[0], a[0], c * 8 + p * 4 + h * 2 + a);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule